// File: doc/BRIEF.md
# Embedded-Clock Frame Lock Detector

This block sits behind a clock-and-data recovery front end. It takes the recovered serial stream one bit at a time, with a bit-valid enable, and finds the frame boundary. Each 18-bit frame holds a start clock bit (1), sixteen payload bits sent least significant first, and a stop clock bit (0). So the only edge that is sure to repeat in every frame is the rising transition from one frame's stop bit into the next frame's start bit.

While hunting, the block keeps a saturating consistency counter for every bit slot of an 18-bit window. A slot that sees a rising edge in enough consecutive frames qualifies. Lock is granted only when exactly one slot qualifies, and that same slot must still be the only one at the next scan. A data pattern that makes a second slot look like a clock edge keeps the block unlocked until the pattern changes.

Once locked, the block drives the active-low lock output low and delivers one payload word with a one-cycle strobe per frame. It falls back to hunting after two frames in a row whose clock bits are wrong. An active-low powerdown input clears all state and holds the block idle.

Top module: `flk_lock_detector`

## Requirements
- R1: After reset, and while powerdown is low, lock_n is 1, word_stb is 0 and word_out is 0.
- R2: A frame is 18 valid bits: a start bit of 1, payload bits 0 to 15 in that order, then a stop bit of 0. word_out bit i carries payload bit i.
- R3: Lock needs one slot with a rising edge in at least 4 consecutive frames, confirmed by one more frame scan. On a clean stream, lock_n stays 1 through the first 4 frames and is 0 once 6 frames have been received.
- R4: If two or more slots qualify, the block does not lock and clears all counters. A stream of constant payload 0x0002, which has rising edges at the boundary and between bits 0 and 1, never gets lock and produces no strobe.
- R5: After an ambiguous stream, a change to a pattern in which only the boundary edge persists leads to lock.
- R6: While locked, exactly one word_stb pulse is produced per good frame, in the cycle after that frame's stop bit is accepted, and word_out then holds that frame's payload.
- R7: word_stb is never 1 while lock_n is 1, and word_out is 0 whenever lock_n is 1.
- R8: Cycles with bit_vld low carry no bit and move nothing on. A stream with idle cycles between bits keeps lock and gives the same words.
- R9: A single frame whose start bit is 0 or whose stop bit is 1 produces no strobe and does not drop lock. The next good frame clears the miss count.
- R10: Two consecutive frames with wrong clock bits drive lock_n to 1 in the cycle after the second frame's stop bit. Hunting then restarts and relocks on a clean stream.
- R11: Because the stop bit is always 0, payload bit 15 set to 1 makes no rising edge into the stop slot. A stream of constant payload 0xFFFF locks and delivers 0xFFFF words.
- R12: Driving powerdown low while locked sets lock_n to 1 in the next cycle. After release, the block hunts from an empty state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous reset, active high |
| pwdn_n | input | 1 | Powerdown, active low; clears and holds idle |
| bit_vld | input | 1 | Qualifies bit_in in this cycle |
| bit_in | input | 1 | Recovered serial bit |
| lock_n | output | 1 | Active-low lock; low means payload words are valid |
| word_out | output | PAY_W | Payload word of the last good frame, 0 when unlocked |
| word_stb | output | 1 | One-cycle strobe marking a new word |

## Verification
The stream starts with an odd-length preamble, so the boundary never lines up with the block's internal scan phase. Alternating zero and varying payloads leave the boundary as the only persistent edge, which shows whether the counters and the confirming scan lock at the right slot and not too early. Constant 0x0002 creates a second persistent edge and separates a correct ambiguity refusal from a detector that takes the first slot to qualify. A walking-one and walking-zero sweep over all sixteen payload bits, with and without idle gaps, checks bit order and strobe timing. Constant 0xFFFF, single bad frames and pairs of bad frames tell apart the bit-15 corner, tolerance of one miss and loss of lock after two.

// File: rtl/flk_pkg.sv
package flk_pkg;

    // number of embedded clock bits per frame (start + stop)
    localparam int unsigned CLK_BITS = 2;

    typedef enum logic [1:0] {
        HUNT_SCAN    = 2'd0,
        HUNT_CONFIRM = 2'd1,
        LOCKED       = 2'd2
    } lock_state_e;

    // end-of-frame report from the word assembler to the lock controller
    typedef struct packed {
        logic done;
        logic ok;
    } frame_stat_t;

    function automatic int unsigned frame_bits(input int unsigned pay_w);
        return pay_w + CLK_BITS;
    endfunction

endpackage

// File: rtl/flk_phase_track.sv
module flk_phase_track #(
    parameter int unsigned FRAME_LEN = 18,
    parameter int unsigned PW        = 5
) (
    input  logic          clk,
    input  logic          clr,
    input  logic          vld,
    input  logic          din,
    output logic [PW-1:0] phase,
    output logic          rise
);
    logic prev_bit;

    // rising edge landing on the current slot
    assign rise = vld && !prev_bit && din;

    always_ff @(posedge clk) begin
        if (clr) begin
            phase    <= '0;
            prev_bit <= 1'b1;
        end else if (vld) begin
            prev_bit <= din;
            phase    <= (phase == PW'(FRAME_LEN - 1)) ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/flk_cand_bank.sv
module flk_cand_bank #(
    parameter int unsigned FRAME_LEN = 18,
    parameter int unsigned QUAL      = 4,
    parameter int unsigned PW        = 5
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 vld,
    input  logic                 rise,
    input  logic [PW-1:0]        phase,
    output logic [FRAME_LEN-1:0] qual
);
    localparam int unsigned CW = $clog2(QUAL + 1);

    for (genvar g = 0; g < FRAME_LEN; g++) begin : g_slot
        logic [CW-1:0] cnt;

        always_ff @(posedge clk) begin
            if (clr) begin
                cnt <= '0;
            end else if (vld && phase == PW'(g)) begin
                if (!rise)
                    cnt <= '0;
                else if (cnt != CW'(QUAL))
                    cnt <= cnt + 1'b1;
            end
        end

        assign qual[g] = (cnt == CW'(QUAL));
    end
endmodule

// File: rtl/flk_lock_ctrl.sv
module flk_lock_ctrl
    import flk_pkg::*;
#(
    parameter int unsigned FRAME_LEN  = 18,
    parameter int unsigned MISS_LIMIT = 2,
    parameter int unsigned PW         = 5
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 vld,
    input  logic [PW-1:0]        phase,
    input  logic [FRAME_LEN-1:0] qual,
    input  frame_stat_t          fstat,
    output logic                 locked,
    output logic [PW-1:0]        anchor,
    output logic                 scan_clr,
    output logic                 drop
);
    localparam int unsigned MW = $clog2(MISS_LIMIT + 1);

    lock_state_e   st;
    logic [PW-1:0] pend;
    logic [PW-1:0] first_idx;
    logic [MW-1:0] miss;
    logic          scan_point;
    logic          lock_now;
    int            n_qual;

    always_comb begin
        first_idx = '0;
        for (int i = FRAME_LEN - 1; i >= 0; i--)
            if (qual[i]) first_idx = PW'(i);
    end

    assign n_qual     = $countones(qual);
    assign scan_point = vld && (phase == '0) && (st != LOCKED);
    assign lock_now   = (st == HUNT_CONFIRM) && scan_point && (n_qual == 1) && (first_idx == pend);
    assign drop       = (st == LOCKED) && fstat.done && !fstat.ok && (miss == MW'(MISS_LIMIT - 1));
    assign scan_clr   = (st == LOCKED) || lock_now || (scan_point && n_qual >= 2);
    assign locked     = (st == LOCKED);

    always_ff @(posedge clk) begin
        if (clr) begin
            st     <= HUNT_SCAN;
            pend   <= '0;
            anchor <= '0;
            miss   <= '0;
        end else begin
            case (st)
                HUNT_SCAN: begin
                    if (scan_point && n_qual == 1) begin
                        pend <= first_idx;
                        st   <= HUNT_CONFIRM;
                    end
                end
                HUNT_CONFIRM: begin
                    if (lock_now) begin
                        st     <= LOCKED;
                        anchor <= pend;
                        miss   <= '0;
                    end else if (scan_point && n_qual == 1) begin
                        pend <= first_idx;
                    end else if (scan_point) begin
                        st <= HUNT_SCAN;
                    end
                end
                LOCKED: begin
                    if (fstat.done) begin
                        if (fstat.ok) begin
                            miss <= '0;
                        end else if (drop) begin
                            st   <= HUNT_SCAN;
                            miss <= '0;
                        end else begin
                            miss <= miss + 1'b1;
                        end
                    end
                end
                default: st <= HUNT_SCAN;
            endcase
        end
    end
endmodule

// File: rtl/flk_word_asm.sv
module flk_word_asm
    import flk_pkg::*;
#(
    parameter int unsigned PAY_W = 16,
    parameter int unsigned PW    = 5
) (
    input  logic             clk,
    input  logic             clr,
    input  logic             active,
    input  logic             vld,
    input  logic             din,
    input  logic [PW-1:0]    rel,
    output frame_stat_t      fstat,
    output logic [PAY_W-1:0] word,
    output logic             stb
);
    localparam int unsigned LAST = PAY_W + 1;

    logic             armed;
    logic             start_ok;
    logic [PAY_W-1:0] shreg;

    always_comb begin
        fstat.done = vld && active && armed && (rel == PW'(LAST));
        fstat.ok   = start_ok && !din;
    end

    always_ff @(posedge clk) begin
        if (clr || !active) begin
            armed    <= 1'b0;
            start_ok <= 1'b0;
            shreg    <= '0;
            word     <= '0;
            stb      <= 1'b0;
        end else begin
            stb <= 1'b0;
            if (vld) begin
                if (rel == '0) begin
                    armed    <= 1'b1;
                    start_ok <= din;
                end else if (rel <= PW'(PAY_W)) begin
                    shreg <= {din, shreg[PAY_W-1:1]};
                end
            end
            if (fstat.done && fstat.ok) begin
                stb  <= 1'b1;
                word <= shreg;
            end
        end
    end
endmodule

// File: rtl/flk_lock_detector.sv
module flk_lock_detector
    import flk_pkg::*;
#(
    parameter int unsigned PAY_W       = 16,
    parameter int unsigned QUAL_FRAMES = 4,
    parameter int unsigned MISS_LIMIT  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             pwdn_n,
    input  logic             bit_vld,
    input  logic             bit_in,
    output logic             lock_n,
    output logic [PAY_W-1:0] word_out,
    output logic             word_stb
);
    localparam int unsigned FRAME_LEN = frame_bits(PAY_W);
    localparam int unsigned PW        = $clog2(FRAME_LEN);

    logic                 hold_clr;
    logic [PW-1:0]        phase;
    logic                 rise;
    logic [FRAME_LEN-1:0] cand_qual;
    logic                 scan_clr;
    logic                 locked;
    logic                 drop;
    logic [PW-1:0]        anchor;
    logic [PW-1:0]        rel;
    frame_stat_t          fstat;

    assign hold_clr = rst || !pwdn_n;

    // slot position relative to the locked start bit, modulo FRAME_LEN
    always_comb begin
        if (phase >= anchor)
            rel = phase - anchor;
        else
            rel = phase + PW'(FRAME_LEN) - anchor;
    end

    flk_phase_track #(.FRAME_LEN(FRAME_LEN), .PW(PW)) u_phase (
        .clk   (clk),
        .clr   (hold_clr),
        .vld   (bit_vld),
        .din   (bit_in),
        .phase (phase),
        .rise  (rise)
    );

    flk_cand_bank #(.FRAME_LEN(FRAME_LEN), .QUAL(QUAL_FRAMES), .PW(PW)) u_bank (
        .clk   (clk),
        .clr   (hold_clr || scan_clr),
        .vld   (bit_vld),
        .rise  (rise),
        .phase (phase),
        .qual  (cand_qual)
    );

    flk_lock_ctrl #(.FRAME_LEN(FRAME_LEN), .MISS_LIMIT(MISS_LIMIT), .PW(PW)) u_ctrl (
        .clk      (clk),
        .clr      (hold_clr),
        .vld      (bit_vld),
        .phase    (phase),
        .qual     (cand_qual),
        .fstat    (fstat),
        .locked   (locked),
        .anchor   (anchor),
        .scan_clr (scan_clr),
        .drop     (drop)
    );

    flk_word_asm #(.PAY_W(PAY_W), .PW(PW)) u_asm (
        .clk    (clk),
        .clr    (hold_clr || drop),
        .active (locked),
        .vld    (bit_vld),
        .din    (bit_in),
        .rel    (rel),
        .fstat  (fstat),
        .word   (word_out),
        .stb    (word_stb)
    );

    assign lock_n = !locked;
endmodule

// File: rtl/flk_lock_checker.sv
module flk_lock_checker #(
    parameter int unsigned PAY_W     = 16,
    parameter int unsigned FRAME_LEN = 18
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 pwdn_n,
    input logic                 bit_vld,
    input logic                 lock_n,
    input logic [PAY_W-1:0]     word_out,
    input logic                 word_stb,
    input logic [FRAME_LEN-1:0] qual
);
    assert_stb_only_locked_R7: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> !lock_n);

    assert_word_zero_unlocked_R7: assert property (@(posedge clk) disable iff (rst)
        lock_n |-> (word_out == '0));

    assert_pwdn_clears_R12: assert property (@(posedge clk) disable iff (rst)
        !pwdn_n |=> (lock_n && !word_stb));

    assert_stb_spacing_R6: assert property (@(posedge clk) disable iff (rst)
        word_stb |=> !word_stb);

    assert_lock_on_valid_bit_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_n) |-> $past(bit_vld));

    assert_single_candidate_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(lock_n) |-> ($countones($past(qual)) == 1));
endmodule

bind flk_lock_detector flk_lock_checker #(.PAY_W(PAY_W), .FRAME_LEN(FRAME_LEN)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .pwdn_n   (pwdn_n),
    .bit_vld  (bit_vld),
    .lock_n   (lock_n),
    .word_out (word_out),
    .word_stb (word_stb),
    .qual     (cand_qual)
);

// File: tb/tb_flk_lock_detector.sv
module tb_flk_lock_detector;
    localparam int unsigned PAY_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             pwdn_n = 1'b1;
    logic             bit_vld = 1'b0;
    logic             bit_in = 1'b0;
    logic             lock_n;
    logic [PAY_W-1:0] word_out;
    logic             word_stb;

    int total = 0;
    int bad = 0;
    int stb_cnt = 0;
    int cyc = 0;
    int gap = 0;
    logic [PAY_W-1:0] exp_word = '0;
    logic             exp_good = 1'b0;

    flk_lock_detector #(.PAY_W(PAY_W)) dut (
        .clk      (clk),
        .rst      (rst),
        .pwdn_n   (pwdn_n),
        .bit_vld  (bit_vld),
        .bit_in   (bit_in),
        .lock_n   (lock_n),
        .word_out (word_out),
        .word_stb (word_stb)
    );

    always #2 clk = ~clk;

    task automatic check(input logic ok, input string tag, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // payload pattern: zero frames keep every data edge from persisting
    function automatic logic [PAY_W-1:0] pat(input int k);
        if (k % 2 == 0) return '0;
        return PAY_W'(k * 945 + 90);
    endfunction

    task automatic send_bit(input logic b);
        @(negedge clk);
        bit_vld = 1'b1;
        bit_in  = b;
        @(posedge clk);
        #1;
        bit_vld = 1'b0;
        repeat (gap) @(posedge clk);
    endtask

    task automatic send_frame(input logic [PAY_W-1:0] w, input logic sb, input logic pb);
        send_bit(sb);
        for (int i = 0; i < PAY_W; i++) send_bit(w[i]);
        exp_word = w;
        exp_good = sb && !pb;
        send_bit(pb);
    endtask

    task automatic power_cycle();
        @(negedge clk);
        pwdn_n = 1'b0;
        @(posedge clk);
        #1;
        check(lock_n == 1'b1 && word_stb == 1'b0 && word_out == '0, "R12 powerdown clears", lock_n, 1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        pwdn_n = 1'b1;
        @(posedge clk);
        #1;
        check(lock_n == 1'b1, "R1 idle after powerdown release", lock_n, 1);
    endtask

    // strobe monitor: word content, only for good frames
    always @(posedge clk) begin
        #1;
        if (word_stb) begin
            stb_cnt++;
            check(word_out == exp_word, "R2 R6 strobed word", word_out, exp_word);
            check(exp_good, "R9 strobe on bad frame", 1, 0);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        check(lock_n == 1'b1 && word_stb == 1'b0 && word_out == '0, "R1 reset state", lock_n, 1);

        // odd preamble so the boundary is off the scan phase
        for (int i = 0; i < 7; i++) send_bit(1'b0);
        for (int f = 0; f < 4; f++) send_frame(pat(f), 1'b1, 1'b0);
        check(lock_n == 1'b1, "R3 no lock within 4 frames", lock_n, 1);
        for (int f = 4; f < 6; f++) send_frame(pat(f), 1'b1, 1'b0);
        check(lock_n == 1'b0, "R3 lock after 6 frames", lock_n, 0);

        stb_cnt = 0;
        for (int f = 6; f < 26; f++) send_frame(pat(f), 1'b1, 1'b0);
        check(stb_cnt == 20, "R6 one strobe per frame", stb_cnt, 20);

        // walking one and walking zero over every payload bit
        stb_cnt = 0;
        for (int i = 0; i < PAY_W; i++) begin
            send_frame(PAY_W'(1) << i, 1'b1, 1'b0);
            send_frame(~(PAY_W'(1) << i), 1'b1, 1'b0);
        end
        check(stb_cnt == 2 * PAY_W, "R2 sweep strobes", stb_cnt, 2 * PAY_W);

        // idle cycles between bits
        gap = 1;
        stb_cnt = 0;
        for (int f = 0; f < 10; f++) send_frame(pat(f + 1), 1'b1, 1'b0);
        check(stb_cnt == 10 && lock_n == 1'b0, "R8 idle gaps keep lock", stb_cnt, 10);
        gap = 2;
        stb_cnt = 0;
        for (int f = 0; f < 4; f++) send_frame(pat(f + 3), 1'b1, 1'b0);
        check(stb_cnt == 4, "R8 wider gaps", stb_cnt, 4);
        gap = 0;

        // single bad frames
        stb_cnt = 0;
        send_frame(16'h1234, 1'b1, 1'b1);
        check(lock_n == 1'b0 && stb_cnt == 0, "R9 bad stop keeps lock", stb_cnt, 0);
        send_frame(16'h4321, 1'b1, 1'b0);
        check(stb_cnt == 1, "R9 next good frame strobes", stb_cnt, 1);
        send_frame(16'h0F0F, 1'b0, 1'b0);
        check(lock_n == 1'b0, "R9 bad start keeps lock", lock_n, 0);
        send_frame(16'h0000, 1'b1, 1'b0);
        send_frame(16'h2222, 1'b1, 1'b1);
        check(lock_n == 1'b0, "R9 miss count cleared by good frame", lock_n, 0);

        // two in a row
        send_frame(16'h5555, 1'b0, 1'b0);
        check(lock_n == 1'b1, "R10 lock lost after two misses", lock_n, 1);
        check(word_out == '0, "R7 word cleared when unlocked", word_out, 0);
        for (int f = 0; f < 6; f++) send_frame(pat(f), 1'b1, 1'b0);
        check(lock_n == 1'b0, "R10 relock after loss", lock_n, 0);

        // powerdown while locked, then ambiguous stream
        power_cycle();
        stb_cnt = 0;
        for (int f = 0; f < 14; f++) begin
            send_frame(16'h0002, 1'b1, 1'b0);
            check(lock_n == 1'b1, "R4 ambiguous pattern stays unlocked", lock_n, 1);
        end
        check(stb_cnt == 0, "R7 no strobe while unlocked", stb_cnt, 0);
        for (int f = 0; f < 8; f++) send_frame(pat(f), 1'b1, 1'b0);
        check(lock_n == 1'b0, "R5 lock after pattern change", lock_n, 0);

        // bit 15 high next to the stop bit
        power_cycle();
        stb_cnt = 0;
        for (int f = 0; f < 10; f++) send_frame(16'hFFFF, 1'b1, 1'b0);
        check(lock_n == 1'b0, "R11 all-ones payload locks", lock_n, 0);
        check(stb_cnt > 0, "R11 all-ones words delivered", stb_cnt, 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule